// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that executes a list of command descriptors stored in memory. Each descriptor can push a short burst of control words into a peripheral's registers, move a buffer from the peripheral's inbound stream into memory, or move a buffer from memory to the peripheral's outbound stream. When a descriptor finishes, the channel follows the descriptor's next pointer or goes idle.

Software sets the address of the first descriptor and then increments a semaphore. The channel runs while the semaphore is nonzero. A descriptor can decrement the semaphore when it finishes, so software can hand work over one descriptor at a time. A ring of descriptors whose last next pointer points back at the first gives endless cyclic transfers, with an interrupt once per period. The peripheral can hold completion back with an end indication, or abort the data phase with a terminate indication.

Top module: `chain_dma_channel`

## Requirements
- R1: A descriptor at byte address A is read as 32-bit words at A, A+4, A+8 and so on. The word at A is the next-descriptor address. The word at A+4 holds the control field in bits [15:0] and the byte count in bits [31:16]. The word at A+8 is the buffer address. Register words start at A+12.
- R2: Control bits [15:12] give N, from 0 to 15. Before any data moves, the channel reads N register words and presents each one on the register-write port with indices 0 to N-1, in order.
- R3: Command code 1 in control bits [1:0] moves ceil(count/4) words from the inbound stream to consecutive memory words, starting at the buffer address. Memory outside that range is not touched.
- R4: Command code 2 moves ceil(count/4) words from consecutive memory words, starting at the buffer address, to the outbound stream, in address order.
- R5: Command code 0, command code 3, or any of control bits 4, 5, 10 or 11 set means no data is moved. The register words are still written and the descriptor still completes.
- R6: A pulse on sema_inc adds one to the semaphore, saturating at its maximum. The channel launches from the stored next-command address only after an increment and only while the semaphore is nonzero. Control bit 6 decrements the semaphore at completion, and the channel stops when the semaphore reaches zero. The semaphore changes by at most one per cycle and never goes below zero.
- R7: Control bit 2 makes the channel fetch the descriptor at the next pointer. With bit 2 clear the channel goes idle, and a later increment resumes at that next pointer without a new address write.
- R8: Control bit 3 produces exactly one irq_done pulse per descriptor completion. A ring with bits 2 and 3 set and bit 6 clear runs without end, interrupting once per descriptor.
- R9: With control bit 7 set, completion waits for periph_end. The channel stays busy and raises no interrupt until periph_end arrives.
- R10: With control bit 8 set, periph_term during the data phase stops the channel and pulses err_term, with no interrupt. The exception is a cycle in which the last word's handshake also happens: the descriptor then completes normally.
- R11: When a terminate stops an inbound transfer while a received word is held, control bit 9 clear writes that word to memory before stopping. Bit 9 set discards it.
- R12: A memory response with mem_err stops the channel at once and pulses err_bus. No completion interrupt follows and the semaphore is not decremented.
- R13: After reset the channel is idle with the semaphore at zero, no memory request, no outbound data and no pulses.
- R14: A memory read request, and outbound data not yet accepted, hold steady until they are accepted unless a terminate intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Load next-command address (accepted while idle) |
| cmd_addr | input | 32 | First descriptor byte address |
| sema_inc | input | 1 | Add one to the semaphore |
| sema_level | output | 8 | Current semaphore value |
| busy | output | 1 | Channel is not idle |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| preg_valid | output | 1 | Register word strobe |
| preg_idx | output | 4 | Register index |
| preg_data | output | 32 | Register word |
| tx_valid | output | 1 | Outbound word valid |
| tx_data | output | 32 | Outbound word |
| tx_ready | input | 1 | Peripheral accepts outbound word |
| rx_valid | input | 1 | Inbound word valid |
| rx_data | input | 32 | Inbound word |
| rx_ready | output | 1 | Channel accepts inbound word |
| periph_end | input | 1 | Peripheral end indication |
| periph_term | input | 1 | Peripheral terminate indication |
| irq_done | output | 1 | Completion interrupt pulse |
| err_term | output | 1 | Termination error pulse |
| err_bus | output | 1 | Bus error pulse |

## Verification
On every cycle the assertions check that the semaphore never underflows and moves by at most one per cycle, that memory read requests and unaccepted outbound words stay stable, and that a bus error never coincides with a completion interrupt. Only the bench scenarios can show the rest. These are the sweeps over register-word counts and byte counts, the chained and ringed descriptor lists, stopping and resuming on the semaphore, the wait for the end indication, and the race between a terminate and the last word. The bench also covers the different effects of the flush bit and the abort on a bus error.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_PIO, S_RD, S_WR, S_DRAIN, S_WAITE, S_FIN
  } dma_state_t;

  typedef struct packed {
    logic       chain;
    logic       irq;
    logic       dec;
    logic       waite;
    logic       halt;
    logic       flush;
    logic       move_rd;
    logic       move_wr;
    logic [3:0] pio_n;
  } dma_ctrl_t;

endpackage

// File: rtl/chain_dma_ctrl_dec.sv
module chain_dma_ctrl_dec
  import chain_dma_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic [31:0]      word,
  output dma_ctrl_t        ctrl,
  output logic [CNT_W-1:0] words
);
  logic [1:0]  cmd;
  logic        rsvd;
  logic [16:0] bsum;

  always_comb begin
    cmd   = word[1:0];
    rsvd  = |{word[11:10], word[5:4]};
    bsum  = {1'b0, word[31:16]} + 17'd3;
    words = bsum[CNT_W+1:2];
    ctrl.chain   = word[2];
    ctrl.irq     = word[3];
    ctrl.dec     = word[6];
    ctrl.waite   = word[7];
    ctrl.halt    = word[8];
    ctrl.flush   = word[9];
    ctrl.pio_n   = word[15:12];
    ctrl.move_wr = (cmd == 2'd1) && !rsvd && (words != '0);
    ctrl.move_rd = (cmd == 2'd2) && !rsvd && (words != '0);
  end
endmodule

// File: rtl/chain_dma_sema.sv
module chain_dma_sema #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] level
);
  logic [W-1:0] level_d;

  always_comb begin
    level_d = level;
    case ({inc, dec})
      2'b10:   if (level != {W{1'b1}}) level_d = level + 1'b1;
      2'b01:   if (level != '0) level_d = level - 1'b1;
      default: level_d = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= level_d;
  end

  // R6: a decrement is only requested while the count is nonzero
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (level != '0));

  // R6: the count moves by at most one per cycle
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((level == $past(level)) || (level == $past(level) + 1'b1) ||
              (level == $past(level) - 1'b1)));
endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEMA_W    = 8,
  parameter int MAX_BYTES = 32'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              sema_inc,
  output logic [SEMA_W-1:0] sema_level,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              preg_valid,
  output logic [3:0]        preg_idx,
  output logic [31:0]       preg_data,
  output logic              tx_valid,
  output logic [31:0]       tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [31:0]       rx_data,
  output logic              rx_ready,
  input  logic              periph_end,
  input  logic              periph_term,
  output logic              irq_done,
  output logic              err_term,
  output logic              err_bus
);
  localparam int CNT_W = $clog2(MAX_BYTES / 4 + 1);
  localparam logic [ADDR_W-1:0] PIO_OFS = ADDR_W'(12);

  dma_state_t        state_q, state_d;
  dma_ctrl_t         ctrl_q, ctrl_d, dec_ctrl;
  logic [CNT_W-1:0]  words_q, words_d, dec_words, idx_q, idx_d;
  logic [ADDR_W-1:0] desc_q, desc_d, next_q, next_d, buf_q, buf_d, ofs;
  logic [31:0]       hold_q, hold_d, pdat_d;
  logic [3:0]        pidx_d;
  logic              have_q, have_d, kick_q, kick_d;
  logic              irq_d, eterm_d, ebus_d, pv_d, sema_dec;
  logic              acc_ok, last_word;
  dma_state_t        after_regs, after_data;

  chain_dma_ctrl_dec #(.CNT_W(CNT_W)) u_dec (
    .word(mem_rdata), .ctrl(dec_ctrl), .words(dec_words));

  chain_dma_sema #(.W(SEMA_W)) u_sema (
    .clk(clk), .rst_n(rst_n), .inc(sema_inc), .dec(sema_dec), .level(sema_level));

  always_comb begin
    ofs        = ADDR_W'({idx_q, 2'b00});
    acc_ok     = mem_ack && !mem_err;
    last_word  = (idx_q == words_q - CNT_W'(1));
    after_data = ctrl_q.waite ? S_WAITE : S_FIN;
    if (ctrl_q.move_wr)      after_regs = S_WR;
    else if (ctrl_q.move_rd) after_regs = S_RD;
    else                     after_regs = after_data;
  end

  always_comb begin
    state_d = state_q;  desc_d = desc_q;  next_d = next_q;  ctrl_d = ctrl_q;
    words_d = words_q;  buf_d = buf_q;    idx_d = idx_q;    hold_d = hold_q;
    have_d  = have_q;   kick_d = kick_q | sema_inc;
    irq_d = 1'b0; eterm_d = 1'b0; ebus_d = 1'b0; pv_d = 1'b0; sema_dec = 1'b0;
    pidx_d = preg_idx; pdat_d = preg_data;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = buf_q + ofs; mem_wdata = hold_q;
    tx_valid = 1'b0; rx_ready = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (cmd_wr) next_d = cmd_addr;
        if (kick_q && sema_level != '0) begin
          state_d = S_FETCH; desc_d = next_q; idx_d = '0; kick_d = sema_inc;
        end
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + ofs;
        if (acc_ok) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == CNT_W'(0)) next_d = mem_rdata[ADDR_W-1:0];
          else if (idx_q == CNT_W'(1)) begin ctrl_d = dec_ctrl; words_d = dec_words; end
          else begin
            buf_d   = mem_rdata[ADDR_W-1:0];
            idx_d   = '0;
            state_d = (ctrl_q.pio_n != 4'd0) ? S_PIO : after_regs;
          end
        end
      end
      S_PIO: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + PIO_OFS + ofs;
        if (acc_ok) begin
          pv_d = 1'b1; pidx_d = idx_q[3:0]; pdat_d = mem_rdata;
          idx_d = idx_q + 1'b1;
          if (idx_q == CNT_W'(ctrl_q.pio_n) - CNT_W'(1)) begin
            idx_d = '0; state_d = after_regs;
          end
        end
      end
      S_RD: begin
        if (!have_q) begin
          mem_req = 1'b1;
          if (acc_ok) begin hold_d = mem_rdata; have_d = 1'b1; end
        end else begin
          tx_valid = 1'b1;
          if (tx_ready) begin
            have_d = 1'b0; idx_d = idx_q + 1'b1;
            if (last_word) state_d = after_data;
          end
        end
        if (periph_term && ctrl_q.halt && !(have_q && tx_ready && last_word)) begin
          state_d = S_IDLE; have_d = 1'b0; eterm_d = 1'b1;
        end
      end
      S_WR: begin
        if (!have_q) begin
          rx_ready = 1'b1;
          if (rx_valid) begin hold_d = rx_data; have_d = 1'b1; end
        end else begin
          mem_req = 1'b1; mem_we = 1'b1;
          if (acc_ok) begin
            have_d = 1'b0; idx_d = idx_q + 1'b1;
            if (last_word) state_d = after_data;
          end
        end
        if (periph_term && ctrl_q.halt && !(have_q && acc_ok && last_word)) begin
          if (have_q && !ctrl_q.flush && !acc_ok) state_d = S_DRAIN;
          else begin state_d = S_IDLE; have_d = 1'b0; eterm_d = 1'b1; end
        end
      end
      S_DRAIN: begin
        mem_req = 1'b1; mem_we = 1'b1;
        if (acc_ok) begin state_d = S_IDLE; have_d = 1'b0; eterm_d = 1'b1; end
      end
      S_WAITE: if (periph_end) state_d = S_FIN;
      S_FIN: begin
        irq_d = ctrl_q.irq;
        if (ctrl_q.dec && sema_level != '0) sema_dec = 1'b1;
        if (ctrl_q.chain && !(ctrl_q.dec && sema_level <= SEMA_W'(1))) begin
          state_d = S_FETCH; desc_d = next_q; idx_d = '0;
        end else state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
    if (mem_req && mem_ack && mem_err) begin
      state_d = S_IDLE; have_d = 1'b0; ebus_d = 1'b1; eterm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; ctrl_q <= '0; words_q <= '0; idx_q <= '0;
      desc_q <= '0; next_q <= '0; buf_q <= '0; hold_q <= '0;
      have_q <= 1'b0; kick_q <= 1'b0;
      irq_done <= 1'b0; err_term <= 1'b0; err_bus <= 1'b0;
      preg_valid <= 1'b0; preg_idx <= '0; preg_data <= '0;
    end else begin
      state_q <= state_d; ctrl_q <= ctrl_d; words_q <= words_d; idx_q <= idx_d;
      desc_q <= desc_d; next_q <= next_d; buf_q <= buf_d;
      if (hold_d != hold_q) hold_q <= hold_d;
      have_q <= have_d; kick_q <= kick_d;
      irq_done <= irq_d; err_term <= eterm_d; err_bus <= ebus_d;
      preg_valid <= pv_d;
      if (pv_d) begin preg_idx <= pidx_d; preg_data <= pdat_d; end
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign tx_data = hold_q;

  // R14: a pending memory read keeps its request and address until acknowledged
  a_r14_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_ack && !periph_term) |=> (mem_req && $stable(mem_addr)));

  // R14: outbound data stays put until the peripheral takes it
  a_r14_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !periph_term) |=> (tx_valid && $stable(tx_data)));

  // R12: a bus error never comes with a completion interrupt
  a_r12_no_irq_on_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_bus |-> !irq_done);
endmodule

// File: tb/chain_dma_channel_bench.sv
module chain_dma_channel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0, sema_inc = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [7:0] sema_level;
  logic busy, mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic preg_valid, tx_valid, rx_ready, irq_done, err_term, err_bus;
  logic [3:0] preg_idx;
  logic [31:0] preg_data, tx_data;
  logic tx_ready = 1'b1, rx_valid = 1'b1, periph_end = 1'b0, periph_term = 1'b0;
  logic [31:0] rx_seq = '0;
  logic err_en = 1'b0;
  logic [31:0] err_addr = '0;

  localparam logic [31:0] B_CHAIN = 32'h4, B_IRQ = 32'h8, B_DEC = 32'h40;
  localparam logic [31:0] B_WAIT = 32'h80, B_HALT = 32'h100, B_FLUSH = 32'h200;

  logic [31:0] mem [0:255];
  logic [31:0] preg_log [0:63];
  logic [3:0]  pidx_log [0:63];
  logic [31:0] tx_log [0:63];
  int n_preg = 0, n_tx = 0, n_irq = 0, n_eterm = 0, n_ebus = 0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  chain_dma_channel u_chain_dma_channel (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .sema_inc(sema_inc), .sema_level(sema_level), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .preg_valid(preg_valid), .preg_idx(preg_idx), .preg_data(preg_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_seq), .rx_ready(rx_ready),
    .periph_end(periph_end), .periph_term(periph_term),
    .irq_done(irq_done), .err_term(err_term), .err_bus(err_bus));

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      mem_err   <= err_en && (mem_addr == err_addr);
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end
    if (rx_valid && rx_ready) rx_seq <= rx_seq + 1;
  end

  always @(negedge clk) begin
    if (preg_valid) begin
      preg_log[n_preg & 63] = preg_data; pidx_log[n_preg & 63] = preg_idx; n_preg++;
    end
    if (tx_valid && tx_ready) begin tx_log[n_tx & 63] = tx_data; n_tx++; end
    if (irq_done) n_irq++;
    if (err_term) n_eterm++;
    if (err_bus)  n_ebus++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_preg = 0; n_tx = 0; n_irq = 0; n_eterm = 0; n_ebus = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clr();
  endtask

  task automatic put_desc(input int w, input logic [31:0] nxt, input logic [31:0] ctrl,
                          input logic [15:0] bytes, input logic [31:0] bufa,
                          input int npio, input logic [31:0] pbase);
    mem[w] = nxt;
    mem[w+1] = {bytes, ctrl[15:0]};
    mem[w+2] = bufa;
    for (int k = 0; k < npio; k++) mem[w+3+k] = pbase + k;
  endtask

  task automatic start(input logic [31:0] a);
    @(negedge clk); cmd_wr = 1'b1; cmd_addr = a;
    @(negedge clk); cmd_wr = 1'b0; sema_inc = 1'b1;
    @(negedge clk); sema_inc = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); sema_inc = 1'b1;
    @(negedge clk); sema_inc = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    do_reset();
    // R13: reset state
    check("R13 busy", {31'd0, busy}, 32'd0);
    check("R13 sema", {24'd0, sema_level}, 32'd0);
    check("R13 mem_req", {31'd0, mem_req}, 32'd0);
    check("R13 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R13 pulses", {29'd0, irq_done, err_term, err_bus}, 32'd0);

    // R2 sweep of register word counts
    for (int n = 0; n < 16; n++) begin
      clr();
      put_desc(0, 0, B_IRQ | B_DEC | (n << 12), 0, 0, n, 32'hA000_0000 + n * 256);
      start(0); wait_idle();
      check("R2 count", n_preg, n);
      for (int k = 0; k < n; k++) begin
        check("R2 data", preg_log[k], 32'hA000_0000 + n * 256 + k);
        check("R2 index", {28'd0, pidx_log[k]}, k);
      end
      check("R8 one irq", n_irq, 1);
      check("R6 sema drained", {24'd0, sema_level}, 0);
    end

    // R4 sweep of outbound byte counts
    for (int b = 1; b <= 12; b++) begin
      clr();
      for (int i = 0; i < 4; i++) mem[128+i] = 32'hB000_0000 + b * 16 + i;
      put_desc(0, 0, 2 | B_IRQ | B_DEC, b, 32'h200, 0, 0);
      start(0); wait_idle();
      check("R4 words", n_tx, (b + 3) / 4);
      for (int i = 0; i < (b + 3) / 4; i++) check("R4 data", tx_log[i], 32'hB000_0000 + b * 16 + i);
      check("R1 irq", n_irq, 1);
    end

    // R3 sweep of inbound byte counts
    for (int b = 1; b <= 12; b++) begin
      clr();
      for (int i = 0; i < 4; i++) mem[128+i] = 32'hDEAD_0000 + i;
      rx_seq = 32'hC000_0000 + b * 16;
      put_desc(0, 0, 1 | B_IRQ | B_DEC, b, 32'h200, 0, 0);
      start(0); wait_idle();
      for (int i = 0; i < 4; i++)
        check("R3 memory", mem[128+i],
              (i < (b + 3) / 4) ? 32'hC000_0000 + b * 16 + i : 32'hDEAD_0000 + i);
    end

    // R5 unsupported command and reserved bit
    clr();
    for (int i = 0; i < 4; i++) mem[128+i] = 32'hDEAD_0000 + i;
    put_desc(0, 0, 3 | B_IRQ | B_DEC | (1 << 12), 8, 32'h200, 1, 32'h5500_0000);
    start(0); wait_idle();
    check("R5 cmd3 no tx", n_tx, 0);
    check("R5 cmd3 pio", n_preg, 1);
    check("R5 cmd3 irq", n_irq, 1);
    clr();
    put_desc(0, 0, 1 | 32'h10 | B_IRQ | B_DEC, 8, 32'h200, 0, 0);
    start(0); wait_idle();
    check("R5 reserved no write", mem[128], 32'hDEAD_0000);
    check("R5 reserved irq", n_irq, 1);

    // R7 R1 three-descriptor chain
    clr();
    mem[128] = 32'h1234_5678;
    put_desc(0, 32'h80, B_CHAIN | (2 << 12), 0, 0, 2, 32'h7700_0000);
    put_desc(32, 32'h100, 2 | B_CHAIN, 4, 32'h200, 0, 0);
    put_desc(64, 0, B_IRQ | B_DEC | (1 << 12), 0, 0, 1, 32'h7800_0000);
    start(0); wait_idle();
    check("R7 chain pio", n_preg, 3);
    check("R7 chain last pio", preg_log[2], 32'h7800_0000);
    check("R7 chain tx", tx_log[0], 32'h1234_5678);
    check("R8 chain irq", n_irq, 1);
    check("R7 chain idle", {31'd0, busy}, 0);

    // R6 R7 semaphore stop and resume
    clr();
    put_desc(0, 32'h80, B_CHAIN | B_DEC | B_IRQ | (1 << 12), 0, 0, 1, 32'h6100_0000);
    put_desc(32, 0, B_IRQ | B_DEC | (1 << 12), 0, 0, 1, 32'h6200_0000);
    start(0); wait_idle();
    check("R6 stop at zero pio", n_preg, 1);
    check("R6 stop sema", {24'd0, sema_level}, 0);
    clr();
    kick(); wait_idle();
    check("R7 resume pio", n_preg, 1);
    check("R7 resume data", preg_log[0], 32'h6200_0000);

    // R9 wait for end
    clr();
    put_desc(0, 0, B_WAIT | B_IRQ | B_DEC, 0, 0, 0, 0);
    start(0);
    repeat (20) @(negedge clk);
    check("R9 still busy", {31'd0, busy}, 1);
    check("R9 no irq yet", n_irq, 0);
    periph_end = 1'b1; @(negedge clk); periph_end = 1'b0;
    wait_idle();
    check("R9 irq after end", n_irq, 1);

    // R8 R10 cyclic ring then terminate
    clr();
    mem[128] = 32'hE000_0000; mem[160] = 32'hE111_1111;
    put_desc(0, 32'h80, 2 | B_CHAIN | B_IRQ | B_HALT, 4, 32'h200, 0, 0);
    put_desc(32, 0, 2 | B_CHAIN | B_IRQ | B_HALT, 4, 32'h280, 0, 0);
    start(0);
    for (int i = 0; i < 4000; i++) begin
      if (n_irq >= 6) break;
      @(negedge clk);
    end
    for (int i = 0; i < 6; i++)
      check("R8 ring data", tx_log[i], (i % 2 == 0) ? 32'hE000_0000 : 32'hE111_1111);
    check("R8 ring running", {31'd0, busy}, 1);
    check("R8 ring sema", {24'd0, sema_level}, 1);
    periph_term = 1'b1; wait_idle(); periph_term = 1'b0;
    check("R10 ring term err", n_eterm, 1);
    check("R10 ring stopped", {31'd0, busy}, 0);
    do_reset();

    // R10 terminate on the last handshake completes normally
    clr();
    put_desc(0, 0, 2 | B_HALT | B_IRQ | B_DEC, 4, 32'h200, 0, 0);
    start(0);
    while (!tx_valid) @(negedge clk);
    periph_term = 1'b1; @(negedge clk); periph_term = 1'b0;
    wait_idle();
    check("R10 same-cycle irq", n_irq, 1);
    check("R10 same-cycle no err", n_eterm, 0);
    check("R10 same-cycle tx", n_tx, 1);
    clr();
    put_desc(0, 0, 2 | B_HALT | B_IRQ | B_DEC, 8, 32'h200, 0, 0);
    start(0);
    while (!tx_valid) @(negedge clk);
    periph_term = 1'b1; @(negedge clk); periph_term = 1'b0;
    wait_idle();
    check("R10 early term err", n_eterm, 1);
    check("R10 early term no irq", n_irq, 0);
    check("R10 early term tx", n_tx, 1);
    do_reset();

    // R11 flush clear keeps the held word, flush set drops it
    for (int f = 0; f < 2; f++) begin
      clr();
      mem[128] = 32'hDEAD_0000;
      rx_seq = 32'h9900_0000 + f;
      put_desc(0, 0, 1 | B_HALT | B_IRQ | B_DEC | (f ? B_FLUSH : 0), 8, 32'h200, 0, 0);
      start(0);
      while (!(mem_req && mem_we)) @(negedge clk);
      periph_term = 1'b1; @(negedge clk); periph_term = 1'b0;
      wait_idle();
      check("R11 term err", n_eterm, 1);
      check("R11 held word", mem[128], f ? 32'hDEAD_0000 : 32'h9900_0000);
      do_reset();
    end

    // R12 bus error on buffer read
    clr();
    put_desc(0, 0, 2 | B_IRQ | B_DEC, 4, 32'h200, 0, 0);
    err_en = 1'b1; err_addr = 32'h200;
    start(0); wait_idle();
    err_en = 1'b0;
    check("R12 bus err", n_ebus, 1);
    check("R12 no irq", n_irq, 0);
    check("R12 no tx", n_tx, 0);
    check("R12 sema kept", {24'd0, sema_level}, 1);
    check("R12 stopped", {31'd0, busy}, 0);
    do_reset();
    check("R13 reset again", {24'd0, sema_level}, 0);

    report();
  end
endmodule